// File: doc/BRIEF.md
# Clock-Synthesizer Configuration Slave (Two-Wire)

This block is a two-wire serial slave that holds the control bytes of a clock synthesizer. A system controller writes and reads the bytes over SCL/SDA. The bytes drive the enables, stop masks and drive modes of the clock-output logic, which receives them as one flat bus. The slave drives SDA only low, through an output enable. It answers to one fixed 7-bit address, 0x69, which is 0xD2 as a write address and 0xD3 as a read address.

The command byte that follows the address selects how the bytes are reached. When bit 7 is 1, the access is indexed and bits 6:0 give the starting offset. When bit 7 is 0, the access is a block transfer: it starts at offset 0 and carries a byte-count byte. The count comes from the master on a write and from the slave on a read. A mode bit held in the bank removes the count byte from both block directions. Offsets advance by one after every data byte. Byte 6 shows three strap inputs in its low bits. The top byte is a fixed identity value.

The control is one state machine with these states:
- ST_IDLE: bus free.
- ST_ADDR: receive the address byte.
- ST_ADDR_ACK: acknowledge the address.
- ST_CMD and ST_CMD_ACK: receive and acknowledge the command.
- ST_CNT and ST_CNT_ACK: receive and acknowledge the block count.
- ST_WDAT and ST_WDAT_ACK: receive and acknowledge a data byte.
- ST_RDAT: shift a byte out.
- ST_RDAT_ACK: sample the master's acknowledge.
- ST_SKIP: wait for the bus to end the transfer.

The transitions are as follows:
- From any state, a start goes to ST_ADDR and a stop goes to ST_IDLE.
- A matching address goes to ST_ADDR_ACK, and a foreign address goes to ST_SKIP.
- After the address acknowledge, a write goes to ST_CMD. A read goes to ST_RDAT.
- After the command acknowledge, a block command with a count goes to ST_CNT. Any other command goes to ST_WDAT.
- After ST_CNT_ACK, the machine goes to ST_WDAT.
- Each ST_WDAT byte goes to ST_WDAT_ACK, which returns to ST_WDAT.
- Each ST_RDAT byte goes to ST_RDAT_ACK. That state returns to ST_RDAT when the master acknowledges, and goes to ST_SKIP when the master does not.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: After reset, the bank holds these values: byte0 0xFF, byte1 0xFE, byte2 0xFF, bytes 3 to 5 0x00, byte6 0x18 OR the strap value, and byte7 0x08. SDA is released.
- R2: Only address 0x69 is acknowledged. After a foreign address, no byte is acknowledged and nothing changes until the next start or stop.
- R3: A command with bit 7 set writes the following data byte at the offset in bits 6:0, MSB first. Every byte is acknowledged.
- R4: An indexed read (command, repeated start, 0xD3) returns the byte at the offset MSB first, and the master ends it with a NACK.
- R5: A block write (command 0x00) takes a count byte and then stores data from offset 0 upward. Data bytes beyond the count are acknowledged but not stored.
- R6: A block read returns the count value 8 first and then bytes from offset 0 upward, until the master NACKs.
- R7: When byte5 bit 7 is 1, both block directions omit the count byte. Data starts at offset 0, and a block write has no count limit.
- R8: Byte6 bits 2:0 follow the strap inputs live and ignore writes. Byte6 bits 7:3 are writable.
- R9: Byte7 reads 0x08 and ignores writes. Writes at offsets 7 and above are acknowledged and discarded. Reads at offsets 8 and above return 0x00.
- R10: A stop after any complete byte ends the transfer. Bytes already stored stay, and later offsets keep their values.
- R11: An indexed write with several data bytes stores them at consecutive offsets.
- R12: SDA is released outside acknowledge slots and outgoing zero bits. The drive enable never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_fs | input | STRAP_W | Latched frequency-select straps |
| cfg_flat | output | 8*NUM_BYTES | All bank bytes, byte i at bits 8i+7:8i |

## Verification
The bench uses the default build: eight bytes, three strap bits, two synchronizer stages and address 0x69. The 7-bit offset field then reaches well past the bank, so offsets 7, 0x10 and 0x20 exercise the discard-on-write and zero-on-read paths. With eight bytes, a block read ends at the identity byte. The bench changes the strap inputs during the run to show that byte 6 follows them live while its writable upper bits hold.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_SKIP
    } smb_state_e;

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_p;
    logic              sda_p;

    // Idle bus is high on both lines, so every stage resets to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_p     <= scl_chain[STAGES-1];
            sda_p     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
    parameter int          NUM_BYTES = 8,
    parameter int          STRAP_W   = 3,
    parameter logic [7:0]  ID_VALUE  = 8'h08,
    localparam int         IDX_W     = $clog2(NUM_BYTES),
    localparam int         WR_BYTES  = NUM_BYTES - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [STRAP_W-1:0]     strap,
    input  logic [6:0]             rd_idx,
    output logic [7:0]             rd_data,
    output logic                   raw_mode,
    output logic [NUM_BYTES*8-1:0] cfg_flat
);

    localparam int         STRAP_BYTE = NUM_BYTES - 2;
    localparam int         MODE_BYTE  = NUM_BYTES - 3;
    localparam int         MODE_BIT   = 7;
    localparam logic [6:0] RD_LIMIT   = 7'(NUM_BYTES);

    function automatic logic [7:0] reset_value(input int idx);
        if (idx == 0 || idx == 2) return 8'hFF;
        if (idx == 1)             return 8'hFE;
        if (idx == STRAP_BYTE)    return 8'h18;
        return 8'h00;
    endfunction

    function automatic logic [7:0] write_mask(input int idx);
        if (idx == STRAP_BYTE) return ~8'((1 << STRAP_W) - 1);
        return 8'hFF;
    endfunction

    logic [7:0] view [NUM_BYTES];

    genvar g;
    generate
        for (g = 0; g < WR_BYTES; g++) begin : g_byte
            localparam logic [7:0] RST_V = reset_value(g);
            localparam logic [7:0] MASK  = write_mask(g);
            logic [7:0] q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= RST_V;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= (wr_data & MASK) | (q & ~MASK);
            end

            // Unwritable bits come from the strap pins instead of storage.
            assign view[g] = (q & MASK) | ({{(8-STRAP_W){1'b0}}, strap} & ~MASK);
        end
    endgenerate

    assign view[NUM_BYTES-1] = ID_VALUE;

    generate
        for (g = 0; g < NUM_BYTES; g++) begin : g_flat
            assign cfg_flat[g*8 +: 8] = view[g];
        end
    endgenerate

    assign rd_data  = (rd_idx < RD_LIMIT) ? view[rd_idx[IDX_W-1:0]] : 8'h00;
    assign raw_mode = view[MODE_BYTE][MODE_BIT];

endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
    import clkcfg_pkg::*;
#(
    parameter int         NUM_BYTES   = 8,
    parameter int         STRAP_W     = 3,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] ID_VALUE    = 8'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [STRAP_W-1:0]     strap_fs,
    output logic [NUM_BYTES*8-1:0] cfg_flat
);

    localparam int         IDX_W    = $clog2(NUM_BYTES);
    localparam logic [6:0] WR_LIMIT = 7'(NUM_BYTES - 1);
    localparam logic [7:0] BLK_CNT  = 8'(NUM_BYTES);
    localparam logic [3:0] BITS     = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_state_e st_q, st_d;
    logic [3:0] bit_q, bit_d;
    logic [7:0] sh_q, sh_d;
    logic       rw_q, rw_d;
    logic       pend_q, pend_d;
    logic       lim_q, lim_d;
    logic [7:0] left_q, left_d;
    logic [6:0] ptr_q, ptr_d;
    logic       nack_q, nack_d;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       rd_data;
    logic             raw_mode;
    logic             byte_done;

    clkcfg_regbank #(
        .NUM_BYTES (NUM_BYTES),
        .STRAP_W   (STRAP_W),
        .ID_VALUE  (ID_VALUE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (sh_q),
        .strap    (strap_fs),
        .rd_idx   (ptr_q),
        .rd_data  (rd_data),
        .raw_mode (raw_mode),
        .cfg_flat (cfg_flat)
    );

    assign byte_done = (bit_q == BITS);

    function automatic logic [6:0] ptr_next(input logic [6:0] p);
        return (p == 7'h7F) ? p : p + 7'd1;
    endfunction

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            bit_q  <= '0;
            sh_q   <= '0;
            rw_q   <= 1'b0;
            pend_q <= 1'b0;
            lim_q  <= 1'b0;
            left_q <= '0;
            ptr_q  <= '0;
            nack_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            bit_q  <= bit_d;
            sh_q   <= sh_d;
            rw_q   <= rw_d;
            pend_q <= pend_d;
            lim_q  <= lim_d;
            left_q <= left_d;
            ptr_q  <= ptr_d;
            nack_q <= nack_d;
        end
    end

    // Next-state and datapath.
    always_comb begin
        st_d   = st_q;
        bit_d  = bit_q;
        sh_d   = sh_q;
        rw_d   = rw_q;
        pend_d = pend_q;
        lim_d  = lim_q;
        left_d = left_q;
        ptr_d  = ptr_q;
        nack_d = nack_q;

        if (stop_det) begin
            st_d = ST_IDLE;
        end else if (start_det) begin
            st_d  = ST_ADDR;
            bit_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SKIP: begin
                end

                ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
                    if (scl_rise && !byte_done) begin
                        sh_d  = {sh_q[6:0], sda_s};
                        bit_d = bit_q + 4'd1;
                    end else if (scl_fall && byte_done) begin
                        bit_d = '0;
                        if (st_q == ST_ADDR) begin
                            if (sh_q[7:1] == DEV_ADDR) begin
                                rw_d = sh_q[0];
                                st_d = ST_ADDR_ACK;
                            end else begin
                                st_d = ST_SKIP;
                            end
                        end else if (st_q == ST_CMD) begin
                            ptr_d  = sh_q[7] ? sh_q[6:0] : 7'd0;
                            pend_d = ~sh_q[7] & ~raw_mode;
                            lim_d  = ~sh_q[7] & ~raw_mode;
                            st_d   = ST_CMD_ACK;
                        end else if (st_q == ST_CNT) begin
                            left_d = sh_q;
                            pend_d = 1'b0;
                            st_d   = ST_CNT_ACK;
                        end else begin
                            ptr_d = ptr_next(ptr_q);
                            if (lim_q && left_q != 8'd0)
                                left_d = left_q - 8'd1;
                            st_d = ST_WDAT_ACK;
                        end
                    end
                end

                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        if (rw_q) begin
                            if (pend_q) begin
                                sh_d   = BLK_CNT;
                                pend_d = 1'b0;
                            end else begin
                                sh_d  = rd_data;
                                ptr_d = ptr_next(ptr_q);
                            end
                            st_d = ST_RDAT;
                        end else begin
                            st_d = ST_CMD;
                        end
                    end
                end

                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        st_d  = pend_q ? ST_CNT : ST_WDAT;
                    end
                end

                ST_CNT_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        bit_d = '0;
                        st_d  = ST_WDAT;
                    end
                end

                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bit_q == 4'd7) begin
                            bit_d = '0;
                            st_d  = ST_RDAT_ACK;
                        end else begin
                            sh_d  = {sh_q[6:0], 1'b0};
                            bit_d = bit_q + 4'd1;
                        end
                    end
                end

                ST_RDAT_ACK: begin
                    if (scl_rise)
                        nack_d = sda_s;
                    if (scl_fall) begin
                        if (nack_q) begin
                            st_d = ST_SKIP;
                        end else begin
                            sh_d  = rd_data;
                            ptr_d = ptr_next(ptr_q);
                            bit_d = '0;
                            st_d  = ST_RDAT;
                        end
                    end
                end

                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        wr_idx = ptr_q[IDX_W-1:0];
        unique case (st_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT: sda_oe = ~sh_q[7];
            ST_WDAT: wr_en = scl_fall && byte_done && !start_det && !stop_det
                             && (ptr_q < WR_LIMIT)
                             && (!lim_q || left_q != 8'd0);
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/clkcfg_smb_checker.sv
module clkcfg_smb_checker
    import clkcfg_pkg::*;
#(
    parameter int NUM_BYTES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input smb_state_e             st,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   scl_s,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [NUM_BYTES*8-1:0] cfg_flat
);

    localparam int LOW_BITS = 8 * (NUM_BYTES - 2);

    assert_oe_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    assert_start_to_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    assert_no_silent_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_flat[LOW_BITS-1:0]));

    assert_write_then_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st == ST_WDAT_ACK && sda_oe));

endmodule

bind clkcfg_smb_slave clkcfg_smb_checker #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .cfg_flat  (cfg_flat)
);

// File: tb/clkcfg_smb_slave_test.sv
module clkcfg_smb_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap_fs = 3'b101;
    logic        sda_oe;
    logic [63:0] cfg_flat;
    logic        sda_line;

    int checks = 0;
    int failures = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_smb_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .strap_fs (strap_fs),
        .cfg_flat (cfg_flat)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bank(input int i);
        return cfg_flat[i*8 +: 8];
    endfunction

    task automatic wq;
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b0; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b1; wq; wq;
    endtask

    task automatic tx_bit(input logic b);
        sda_m = b; wq;
        scl_m = 1'b1; wq; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic rx_bit(output logic b);
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        b = sda_line; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
        rx_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rx_bit(b);
            v[i] = b;
        end
        tx_bit(last);
    endtask

    task automatic put_byte(input logic [6:0] off, input logic [7:0] v, input string req);
        logic a1, a2, a3;
        bus_start;
        wr_byte(8'hD2, a1);
        wr_byte({1'b1, off}, a2);
        wr_byte(v, a3);
        bus_stop;
        check1({req, " indexed write acks"}, a1 & a2 & a3, 1'b1);
    endtask

    task automatic get_byte(input logic [6:0] off, output logic [7:0] v, input string req);
        logic a1, a2, a3;
        bus_start;
        wr_byte(8'hD2, a1);
        wr_byte({1'b1, off}, a2);
        bus_start;
        wr_byte(8'hD3, a3);
        rd_byte(v, 1'b1);
        bus_stop;
        check1({req, " indexed read acks"}, a1 & a2 & a3, 1'b1);
    endtask

    task automatic t_reset;
        logic [7:0] exp [8] = '{8'hFF, 8'hFE, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h1D, 8'h08};
        for (int i = 0; i < 8; i++) check8("R1 reset byte", bank(i), exp[i]);
        check1("R12 released after reset", sda_oe, 1'b0);
    endtask

    task automatic t_foreign;
        logic a;
        bus_start;
        wr_byte(8'hA0, a); check1("R2 foreign address nack", a, 1'b0);
        wr_byte(8'h81, a); check1("R2 following byte nack", a, 1'b0);
        wr_byte(8'h00, a); check1("R2 data byte nack", a, 1'b0);
        bus_stop;
        check8("R2 byte1 untouched", bank(1), 8'hFE);
        check1("R12 released after foreign", sda_oe, 1'b0);
    endtask

    task automatic t_byte_write;
        put_byte(7'd3, 8'hA5, "R3");
        check8("R3 byte3 written", bank(3), 8'hA5);
    endtask

    task automatic t_byte_read;
        logic [7:0] v;
        get_byte(7'd3, v, "R4"); check8("R4 read byte3", v, 8'hA5);
        get_byte(7'd1, v, "R4"); check8("R4 read byte1", v, 8'hFE);
    endtask

    task automatic t_block_write;
        logic a, all;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        all = 1'b1;
        bus_start;
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h00, a); all &= a;
        wr_byte(8'h03, a); all &= a;
        for (int i = 0; i < 4; i++) begin wr_byte(d[i], a); all &= a; end
        bus_stop;
        check1("R5 block write acks incl. over-count", all, 1'b1);
        check8("R5 byte0", bank(0), 8'h11);
        check8("R5 byte1", bank(1), 8'h22);
        check8("R5 byte2", bank(2), 8'h33);
        check8("R5 byte3 beyond count kept", bank(3), 8'hA5);
    endtask

    task automatic t_block_read;
        logic a1, a2, a3;
        logic [7:0] v;
        logic [7:0] exp [8] = '{8'h11, 8'h22, 8'h33, 8'hA5, 8'h00, 8'h00, 8'h1D, 8'h08};
        bus_start;
        wr_byte(8'hD2, a1);
        wr_byte(8'h00, a2);
        bus_start;
        wr_byte(8'hD3, a3);
        check1("R6 block read acks", a1 & a2 & a3, 1'b1);
        rd_byte(v, 1'b0);
        check8("R6 count byte", v, 8'h08);
        for (int i = 0; i < 8; i++) begin
            rd_byte(v, i == 7);
            check8("R6 block data", v, exp[i]);
        end
        bus_stop;
    endtask

    task automatic t_strap;
        logic [7:0] v;
        put_byte(7'd6, 8'hE0, "R8");
        check8("R8 upper written, straps kept", bank(6), 8'hE5);
        strap_fs = 3'b010;
        wq;
        get_byte(7'd6, v, "R8");
        check8("R8 straps follow pins", v, 8'hE2);
    endtask

    task automatic t_readonly;
        logic [7:0] v;
        put_byte(7'd7, 8'hFF, "R9");
        check8("R9 id byte unchanged", bank(7), 8'h08);
        put_byte(7'h20, 8'h77, "R9");
        check8("R9 out-of-range write discarded", bank(0), 8'h11);
        check8("R9 out-of-range write byte6", bank(6), 8'hE2);
        get_byte(7'h10, v, "R9");
        check8("R9 out-of-range read zero", v, 8'h00);
    endtask

    task automatic t_raw;
        logic a, all;
        logic [7:0] v;
        put_byte(7'd5, 8'h80, "R7");
        all = 1'b1;
        bus_start;
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h00, a); all &= a;
        wr_byte(8'h5A, a); all &= a;
        wr_byte(8'h6B, a); all &= a;
        bus_stop;
        check1("R7 raw block write acks", all, 1'b1);
        check8("R7 raw byte0", bank(0), 8'h5A);
        check8("R7 raw byte1", bank(1), 8'h6B);
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start;
        wr_byte(8'hD3, a);
        rd_byte(v, 1'b0); check8("R7 raw read first is byte0", v, 8'h5A);
        rd_byte(v, 1'b1); check8("R7 raw read second is byte1", v, 8'h6B);
        bus_stop;
        put_byte(7'd5, 8'h00, "R7");
        check8("R7 mode cleared", bank(5), 8'h00);
    endtask

    task automatic t_partial;
        logic a, all;
        all = 1'b1;
        bus_start;
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h00, a); all &= a;
        wr_byte(8'h05, a); all &= a;
        wr_byte(8'h01, a); all &= a;
        wr_byte(8'h02, a); all &= a;
        bus_stop;
        check1("R10 partial block acks", all, 1'b1);
        check8("R10 byte0", bank(0), 8'h01);
        check8("R10 byte1", bank(1), 8'h02);
        check8("R10 byte2 untouched", bank(2), 8'h33);
        check1("R10 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_autoinc;
        logic a, all;
        all = 1'b1;
        bus_start;
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h84, a); all &= a;
        wr_byte(8'h44, a); all &= a;
        wr_byte(8'h55, a); all &= a;
        bus_stop;
        check1("R11 acks", all, 1'b1);
        check8("R11 byte4", bank(4), 8'h44);
        check8("R11 byte5", bank(5), 8'h55);
        check8("R11 byte3 untouched", bank(3), 8'hA5);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_foreign;
        t_byte_write;
        t_byte_read;
        t_block_write;
        t_block_read;
        t_strap;
        t_readonly;
        t_raw;
        t_partial;
        t_autoinc;
        check1("R12 released at end", sda_oe, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R12 actual=%0d cycles expected=completion", WD_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule